// File: doc/BRIEF.md
# Debug Mode Access Controller

This block decides which host debug commands may run on a chip that has a single-wire debug port. The commands fall into two classes. Hardware-class commands read and write memory and the port's status byte, and one of them forces debug entry. Firmware-class commands read and write CPU registers, and one of them exits debug. Whether a class is accepted depends on three things: the security state, whether the chip is in special single-chip mode, and the controller's own enable bit and active flag.

Debug entry can be requested in three ways: by the host, by the CPU's software-break instruction, or by the breakpoint unit. A request is held toward the CPU until an instruction boundary is reached. After a secured special single-chip reset, the controller runs an unlock check against a flash-erased status. If that check fails, hardware-class commands still work, so the host can erase the flash, while firmware-class commands stay locked.

Top module: `dbg_access_ctrl`

## Requirements
- R1: After a reset that is not in special single-chip mode, the following outputs are all low: enable, active, both permits, request, unsecure flag, accept and error.
- R2: After a reset in special single-chip mode with `secured_i` low, enable and active are both set, and `hw_permit_o` and `fw_permit_o` are both high.
- R3: `cmd_i` encodes the command as follows: 0 memory read, 1 memory write, 2 status read, 3 status write, 4 force-background, 5 CPU register read, 6 CPU register write, 7 exit. Codes 0, 1 and 4 need `hw_permit_o`. Codes 2 and 3 need only that access is allowed, not the enable bit. Each command gives exactly one pulse, one cycle after the command cycle: either `cmd_accept_o` or `cmd_err_o`.
- R4: Codes 5 to 7 are accepted only when the device is unsecured (or has been unlocked) and debug is active.
- R5: An accepted status write loads `cmd_wdata_i` bit 7 into the enable bit on the command edge. The permit outputs follow one cycle later.
- R6: When enabled and not active, a pulse from the host force-background command, from `cpu_bgnd_i`, or from `bkpt_req_i` with `bkpt_tag_i`=1 raises `dbg_req_o`. The next `instr_boundary_i` sets active and drops the request. With enable low, these pulses are ignored.
- R7: A breakpoint with `bkpt_tag_i`=0 (force) lets one instruction boundary pass and enters debug on the second one.
- R8: An accepted exit command clears active and leaves the enable bit set.
- R9: When secured and not in special single-chip mode, every command is rejected and activation sources are ignored.
- R10: A secured special single-chip reset starts an erase check, and all commands are rejected until it ends. If `erase_done_i` arrives with `flash_erased_i`=1, `unsec_o` and enable are set, and all commands are then allowed.
- R11: If `erase_done_i` arrives with `flash_erased_i`=0, only enable is set. Hardware-class commands are then accepted, and firmware-class commands are rejected.
- R12: An accepted memory command (code 0 or 1) copies `paged_en_i` to `cmd_paged_o`. Status-register commands never report a paged access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_special_i | input | 1 | Special single-chip mode |
| secured_i | input | 1 | Device security state |
| erase_done_i | input | 1 | Erase check finished (pulse) |
| flash_erased_i | input | 1 | Flash reads as erased |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_i | input | 3 | Command code (see R3) |
| cmd_wdata_i | input | 8 | Status write data |
| paged_en_i | input | 1 | Paged access requested |
| cpu_bgnd_i | input | 1 | CPU software-break instruction |
| bkpt_req_i | input | 1 | Breakpoint unit request |
| bkpt_tag_i | input | 1 | Breakpoint type: 1 tag, 0 force |
| instr_boundary_i | input | 1 | CPU instruction boundary |
| cmd_accept_o | output | 1 | Command accepted pulse |
| cmd_err_o | output | 1 | Command rejected pulse |
| cmd_paged_o | output | 1 | Accepted access is paged |
| hw_permit_o | output | 1 | Hardware-class permit |
| fw_permit_o | output | 1 | Firmware-class permit |
| dbg_enabled_o | output | 1 | Enable bit |
| dbg_active_o | output | 1 | Debug active flag |
| dbg_req_o | output | 1 | Debug entry request to CPU |
| unsec_o | output | 1 | Unlocked by erase check |

## Verification
The hardest state to reach is the locked hardware-only state. Getting there needs a reset with both special mode and security held, then an erase-done pulse while the flash reads not-erased. Only after that can the bench show that memory writes pass while register reads and exit fail. A second difficult case is the force-type breakpoint, which needs two separate boundary pulses, with the bench checking that active is still low after the first one.

// File: rtl/dbg_acc_pkg.sv
package dbg_acc_pkg;
  localparam int CMD_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_RD_MEM  = 3'd0,
    CMD_WR_MEM  = 3'd1,
    CMD_RD_STAT = 3'd2,
    CMD_WR_STAT = 3'd3,
    CMD_BKGND   = 3'd4,
    CMD_RD_CPU  = 3'd5,
    CMD_WR_CPU  = 3'd6,
    CMD_EXIT    = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    UL_IDLE,
    UL_CHECK,
    UL_UNLOCKED,
    UL_LOCKED_HW
  } ul_state_e;
endpackage

// File: rtl/dbg_unlock_fsm.sv
module dbg_unlock_fsm
  import dbg_acc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boot_i,
  input  logic special_i,
  input  logic secured_i,
  input  logic erase_done_i,
  input  logic flash_erased_i,
  output logic set_en_o,
  output logic unlocked_o,
  output logic decided_o
);
  ul_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    set_en_o = 1'b0;
    unique case (state_q)
      UL_IDLE:  if (boot_i && special_i && secured_i) state_d = UL_CHECK;
      UL_CHECK: if (erase_done_i) begin
        set_en_o = 1'b1;
        state_d  = flash_erased_i ? UL_UNLOCKED : UL_LOCKED_HW;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= UL_IDLE;
    else         state_q <= state_d;
  end

  assign unlocked_o = (state_q == UL_UNLOCKED);
  assign decided_o  = (state_q == UL_UNLOCKED) || (state_q == UL_LOCKED_HW);
endmodule

// File: rtl/dbg_cmd_gate.sv
module dbg_cmd_gate
  import dbg_acc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             secured_i,
  input  logic             special_i,
  input  logic             unlocked_i,
  input  logic             decided_i,
  input  logic             enabled_i,
  input  logic             active_i,
  input  logic             cmd_valid_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             paged_en_i,
  output logic             allow_o,
  output logic             hw_permit_o,
  output logic             fw_permit_o,
  output logic             stat_wr_o,
  output logic             exit_o,
  output logic             bkgnd_o,
  output logic             accept_o,
  output logic             err_o,
  output logic             paged_o
);
  logic allow_d, hw_d, fw_d, unsec_eff;
  logic allow_q, hw_q, fw_q;
  logic ok, fire, is_mem;
  cmd_e cmd;

  assign unsec_eff = !secured_i || unlocked_i;
  assign allow_d   = unsec_eff || (special_i && decided_i);
  assign hw_d      = allow_d && enabled_i;
  assign fw_d      = unsec_eff && active_i && enabled_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      allow_q <= 1'b0;
      hw_q    <= 1'b0;
      fw_q    <= 1'b0;
    end else begin
      allow_q <= allow_d;
      hw_q    <= hw_d;
      fw_q    <= fw_d;
    end
  end

  assign cmd = cmd_e'(cmd_i);

  always_comb begin
    unique case (cmd)
      CMD_RD_MEM, CMD_WR_MEM, CMD_BKGND: ok = hw_q;
      CMD_RD_STAT, CMD_WR_STAT:          ok = allow_q;
      default:                           ok = fw_q;
    endcase
  end

  assign fire   = cmd_valid_i && ok;
  assign is_mem = (cmd == CMD_RD_MEM) || (cmd == CMD_WR_MEM);

  assign stat_wr_o = fire && (cmd == CMD_WR_STAT);
  assign exit_o    = fire && (cmd == CMD_EXIT);
  assign bkgnd_o   = fire && (cmd == CMD_BKGND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_o <= 1'b0;
      err_o    <= 1'b0;
      paged_o  <= 1'b0;
    end else begin
      accept_o <= fire;
      err_o    <= cmd_valid_i && !ok;
      paged_o  <= fire && is_mem && paged_en_i;
    end
  end

  assign allow_o     = allow_q;
  assign hw_permit_o = hw_q;
  assign fw_permit_o = fw_q;
endmodule

// File: rtl/dbg_activation.sv
module dbg_activation #(
  parameter int FORCE_SKIP = 1,
  localparam int SKIP_W = (FORCE_SKIP > 0) ? $clog2(FORCE_SKIP + 1) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic boot_i,
  input  logic special_i,
  input  logic boot_en_i,
  input  logic set_en_i,
  input  logic stat_wr_i,
  input  logic stat_val_i,
  input  logic exit_i,
  input  logic allow_i,
  input  logic host_bkgnd_i,
  input  logic cpu_bgnd_i,
  input  logic bkpt_req_i,
  input  logic bkpt_tag_i,
  input  logic boundary_i,
  output logic enabled_o,
  output logic active_o,
  output logic req_o
);
  logic en_q, act_q, pend_q;
  logic [SKIP_W-1:0] skip_q;
  logic any_src, force_only, src_ok;

  assign any_src    = host_bkgnd_i || cpu_bgnd_i || bkpt_req_i;
  assign force_only = bkpt_req_i && !bkpt_tag_i && !host_bkgnd_i && !cpu_bgnd_i;
  assign src_ok     = allow_i && en_q && !act_q && any_src;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      skip_q <= '0;
    end else if (boot_i && special_i) begin
      act_q <= 1'b1;
      en_q  <= boot_en_i;
    end else begin
      if (set_en_i)       en_q <= 1'b1;
      else if (stat_wr_i) en_q <= stat_val_i;

      if (exit_i) act_q <= 1'b0;
      else if (pend_q && boundary_i && skip_q == '0) act_q <= 1'b1;

      if (pend_q) begin
        if (boundary_i) begin
          if (skip_q != '0) skip_q <= skip_q - 1'b1;
          else              pend_q <= 1'b0;
        end
      end else if (src_ok) begin
        pend_q <= 1'b1;
        skip_q <= force_only ? SKIP_W'(FORCE_SKIP) : '0;
      end
    end
  end

  assign enabled_o = en_q;
  assign active_o  = act_q;
  assign req_o     = pend_q;
endmodule

// File: rtl/dbg_access_ctrl.sv
module dbg_access_ctrl
  import dbg_acc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int EN_BIT     = 7,
  parameter int FORCE_SKIP = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_special_i,
  input  logic              secured_i,
  input  logic              erase_done_i,
  input  logic              flash_erased_i,
  input  logic              cmd_valid_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [DATA_W-1:0] cmd_wdata_i,
  input  logic              paged_en_i,
  input  logic              cpu_bgnd_i,
  input  logic              bkpt_req_i,
  input  logic              bkpt_tag_i,
  input  logic              instr_boundary_i,
  output logic              cmd_accept_o,
  output logic              cmd_err_o,
  output logic              cmd_paged_o,
  output logic              hw_permit_o,
  output logic              fw_permit_o,
  output logic              dbg_enabled_o,
  output logic              dbg_active_o,
  output logic              dbg_req_o,
  output logic              unsec_o
);
  logic boot_q;
  logic set_en, unlocked, decided, allow;
  logic stat_wr, exit_cmd, bkgnd;
  logic unused_wdata;

  assign unused_wdata = ^cmd_wdata_i;

  // one-shot marking the first clock after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) boot_q <= 1'b1;
    else         boot_q <= 1'b0;
  end

  dbg_unlock_fsm u_unlock (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .boot_i         (boot_q),
    .special_i      (mode_special_i),
    .secured_i      (secured_i),
    .erase_done_i   (erase_done_i),
    .flash_erased_i (flash_erased_i),
    .set_en_o       (set_en),
    .unlocked_o     (unlocked),
    .decided_o      (decided)
  );

  dbg_cmd_gate u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .secured_i   (secured_i),
    .special_i   (mode_special_i),
    .unlocked_i  (unlocked),
    .decided_i   (decided),
    .enabled_i   (dbg_enabled_o),
    .active_i    (dbg_active_o),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .paged_en_i  (paged_en_i),
    .allow_o     (allow),
    .hw_permit_o (hw_permit_o),
    .fw_permit_o (fw_permit_o),
    .stat_wr_o   (stat_wr),
    .exit_o      (exit_cmd),
    .bkgnd_o     (bkgnd),
    .accept_o    (cmd_accept_o),
    .err_o       (cmd_err_o),
    .paged_o     (cmd_paged_o)
  );

  dbg_activation #(.FORCE_SKIP(FORCE_SKIP)) u_act (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .boot_i       (boot_q),
    .special_i    (mode_special_i),
    .boot_en_i    (!secured_i),
    .set_en_i     (set_en),
    .stat_wr_i    (stat_wr),
    .stat_val_i   (cmd_wdata_i[EN_BIT]),
    .exit_i       (exit_cmd),
    .allow_i      (allow),
    .host_bkgnd_i (bkgnd),
    .cpu_bgnd_i   (cpu_bgnd_i),
    .bkpt_req_i   (bkpt_req_i),
    .bkpt_tag_i   (bkpt_tag_i),
    .boundary_i   (instr_boundary_i),
    .enabled_o    (dbg_enabled_o),
    .active_o     (dbg_active_o),
    .req_o        (dbg_req_o)
  );

  assign unsec_o = unlocked;
endmodule

// File: rtl/dbg_access_ctrl_chk.sv
module dbg_access_ctrl_chk
  import dbg_acc_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             boot_q,
  input logic             mode_special_i,
  input logic             secured_i,
  input logic             cmd_valid_i,
  input logic [CMD_W-1:0] cmd_i,
  input logic             instr_boundary_i,
  input logic             cmd_accept_o,
  input logic             cmd_err_o,
  input logic             cmd_paged_o,
  input logic             hw_permit_o,
  input logic             fw_permit_o,
  input logic             dbg_enabled_o,
  input logic             dbg_active_o,
  input logic             dbg_req_o,
  input logic             unsec_o
);
  p_one_resp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (cmd_accept_o != cmd_err_o));

  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !(cmd_accept_o || cmd_err_o));

  p_fw_needs_active_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_permit_o |-> $past(dbg_active_o));

  p_hw_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_permit_o |-> $past(dbg_enabled_o));

  p_req_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_req_o && !instr_boundary_i) |=> dbg_req_o);

  p_entry_at_boundary_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dbg_active_o) |-> ($past(boot_q) || $past(dbg_req_o && instr_boundary_i)));

  p_exit_keeps_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == CMD_EXIT && fw_permit_o) |=> (!dbg_active_o && dbg_enabled_o));

  p_secure_normal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secured_i && !mode_special_i && !unsec_o) |=> !hw_permit_o);

  p_locked_fw_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secured_i && !unsec_o) |=> !fw_permit_o);

  p_paged_acc_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_paged_o |-> cmd_accept_o);
endmodule

bind dbg_access_ctrl dbg_access_ctrl_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .boot_q           (boot_q),
  .mode_special_i   (mode_special_i),
  .secured_i        (secured_i),
  .cmd_valid_i      (cmd_valid_i),
  .cmd_i            (cmd_i),
  .instr_boundary_i (instr_boundary_i),
  .cmd_accept_o     (cmd_accept_o),
  .cmd_err_o        (cmd_err_o),
  .cmd_paged_o      (cmd_paged_o),
  .hw_permit_o      (hw_permit_o),
  .fw_permit_o      (fw_permit_o),
  .dbg_enabled_o    (dbg_enabled_o),
  .dbg_active_o     (dbg_active_o),
  .dbg_req_o        (dbg_req_o),
  .unsec_o          (unsec_o)
);

// File: tb/tb_dbg_access_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_access_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       mode_special_i = 1'b0, secured_i = 1'b0;
  logic       erase_done_i = 1'b0, flash_erased_i = 1'b0;
  logic       cmd_valid_i = 1'b0;
  logic [2:0] cmd_i = '0;
  logic [7:0] cmd_wdata_i = '0;
  logic       paged_en_i = 1'b0, cpu_bgnd_i = 1'b0;
  logic       bkpt_req_i = 1'b0, bkpt_tag_i = 1'b0, instr_boundary_i = 1'b0;
  logic       cmd_accept_o, cmd_err_o, cmd_paged_o, hw_permit_o, fw_permit_o;
  logic       dbg_enabled_o, dbg_active_o, dbg_req_o, unsec_o;

  int ntests = 0, nfail = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk_i = ~clk_i;

  dbg_access_ctrl dut (.*);

  task automatic chk(string r, logic act, logic exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0b expected=%0b", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  // driver: push expected {accept, paged}, then strobe the command for one cycle
  task automatic send(logic [2:0] c, logic [7:0] d, logic pg, logic eacc, logic epg, string r);
    @(negedge clk_i);
    exp_q.push_back({eacc, epg});
    tag_q.push_back(r);
    cmd_valid_i = 1'b1; cmd_i = c; cmd_wdata_i = d; paged_en_i = pg;
    @(negedge clk_i);
    cmd_valid_i = 1'b0; paged_en_i = 1'b0;
  endtask

  // monitor: each response pulse is compared with the queued expectation
  always @(negedge clk_i) begin
    if (rst_ni && (cmd_accept_o || cmd_err_o)) begin
      ntests++;
      if (exp_q.size() == 0) begin
        nfail++;
        $display("FAIL unexpected response actual=%0b%0b expected=none", cmd_accept_o, cmd_err_o);
      end else begin
        logic [1:0] e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        if (cmd_accept_o !== e[1] || cmd_err_o !== !e[1] || cmd_paged_o !== e[0]) begin
          nfail++;
          $display("FAIL %s actual acc=%0b err=%0b pg=%0b expected acc=%0b pg=%0b",
                   r, cmd_accept_o, cmd_err_o, cmd_paged_o, e[1], e[0]);
        end
      end
    end
  end

  task automatic do_reset(logic sp, logic sec);
    @(negedge clk_i);
    rst_ni = 1'b0; mode_special_i = sp; secured_i = sec;
    erase_done_i = 1'b0; flash_erased_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic pulse_bgnd();
    @(negedge clk_i); cpu_bgnd_i = 1'b1;
    @(negedge clk_i); cpu_bgnd_i = 1'b0;
  endtask

  task automatic pulse_bkpt(logic tg);
    @(negedge clk_i); bkpt_req_i = 1'b1; bkpt_tag_i = tg;
    @(negedge clk_i); bkpt_req_i = 1'b0; bkpt_tag_i = 1'b0;
  endtask

  task automatic pulse_bnd();
    @(negedge clk_i); instr_boundary_i = 1'b1;
    @(negedge clk_i); instr_boundary_i = 1'b0;
  endtask

  task automatic pulse_erase(logic erased);
    @(negedge clk_i); erase_done_i = 1'b1; flash_erased_i = erased;
    @(negedge clk_i); erase_done_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    // unsecured, normal mode
    do_reset(1'b0, 1'b0);
    chk("R1 enabled", dbg_enabled_o, 1'b0);
    chk("R1 active", dbg_active_o, 1'b0);
    chk("R1 hw_permit", hw_permit_o, 1'b0);
    chk("R1 fw_permit", fw_permit_o, 1'b0);
    chk("R1 req", dbg_req_o, 1'b0);
    chk("R1 unsec", unsec_o, 1'b0);
    send(3'd0, 8'h00, 1'b0, 1'b0, 1'b0, "R3 mem read before enable");
    send(3'd2, 8'h00, 1'b1, 1'b1, 1'b0, "R12 status read never paged");
    send(3'd5, 8'h00, 1'b0, 1'b0, 1'b0, "R4 cpu read inactive");
    send(3'd3, 8'h80, 1'b0, 1'b1, 1'b0, "R5 status write enable");
    chk("R5 enable set", dbg_enabled_o, 1'b1);
    chk("R5 permit lags", hw_permit_o, 1'b0);
    tick();
    chk("R5 permit follows", hw_permit_o, 1'b1);
    send(3'd1, 8'h00, 1'b1, 1'b1, 1'b1, "R12 paged mem write");
    send(3'd0, 8'h00, 1'b0, 1'b1, 1'b0, "R12 unpaged mem read");
    send(3'd5, 8'h00, 1'b0, 1'b0, 1'b0, "R4 cpu read enabled inactive");
    pulse_bgnd();
    chk("R6 bgnd req", dbg_req_o, 1'b1);
    chk("R6 not yet active", dbg_active_o, 1'b0);
    pulse_bnd();
    chk("R6 bgnd active", dbg_active_o, 1'b1);
    chk("R6 req dropped", dbg_req_o, 1'b0);
    tick();
    chk("R4 fw permit", fw_permit_o, 1'b1);
    send(3'd5, 8'h00, 1'b0, 1'b1, 1'b0, "R4 cpu read active");
    send(3'd7, 8'h00, 1'b0, 1'b1, 1'b0, "R8 exit");
    chk("R8 inactive", dbg_active_o, 1'b0);
    chk("R8 still enabled", dbg_enabled_o, 1'b1);
    tick();
    pulse_bkpt(1'b0);
    chk("R7 force req", dbg_req_o, 1'b1);
    pulse_bnd();
    chk("R7 first boundary skipped", dbg_active_o, 1'b0);
    chk("R7 req held", dbg_req_o, 1'b1);
    pulse_bnd();
    chk("R7 second boundary enters", dbg_active_o, 1'b1);
    tick();
    send(3'd7, 8'h00, 1'b0, 1'b1, 1'b0, "R8 exit after force");
    tick();
    pulse_bkpt(1'b1);
    chk("R6 tag req", dbg_req_o, 1'b1);
    pulse_bnd();
    chk("R6 tag enters", dbg_active_o, 1'b1);
    tick();
    send(3'd7, 8'h00, 1'b0, 1'b1, 1'b0, "R8 exit after tag");
    tick();
    send(3'd4, 8'h00, 1'b0, 1'b1, 1'b0, "R6 host background");
    chk("R6 host req", dbg_req_o, 1'b1);
    pulse_bnd();
    chk("R6 host enters", dbg_active_o, 1'b1);
    tick();
    send(3'd7, 8'h00, 1'b0, 1'b1, 1'b0, "R8 exit after host");
    tick();
    send(3'd3, 8'h00, 1'b0, 1'b1, 1'b0, "R5 status write clear");
    chk("R5 enable cleared", dbg_enabled_o, 1'b0);
    tick();
    pulse_bgnd();
    chk("R6 disabled bgnd ignored", dbg_req_o, 1'b0);
    send(3'd1, 8'h00, 1'b0, 1'b0, 1'b0, "R3 mem write disabled");

    // unsecured special reset
    do_reset(1'b1, 1'b0);
    chk("R2 enabled", dbg_enabled_o, 1'b1);
    chk("R2 active", dbg_active_o, 1'b1);
    chk("R2 hw_permit", hw_permit_o, 1'b1);
    chk("R2 fw_permit", fw_permit_o, 1'b1);

    // secured normal mode
    do_reset(1'b0, 1'b1);
    send(3'd3, 8'h80, 1'b0, 1'b0, 1'b0, "R9 status write rejected");
    chk("R9 enable stays low", dbg_enabled_o, 1'b0);
    send(3'd2, 8'h00, 1'b0, 1'b0, 1'b0, "R9 status read rejected");
    pulse_bkpt(1'b1);
    chk("R9 breakpoint ignored", dbg_req_o, 1'b0);

    // secured special, flash erased
    do_reset(1'b1, 1'b1);
    send(3'd2, 8'h00, 1'b0, 1'b0, 1'b0, "R10 status read during check");
    chk("R10 unsec low during check", unsec_o, 1'b0);
    chk("R10 hw permit low during check", hw_permit_o, 1'b0);
    pulse_erase(1'b1);
    chk("R10 unsec set", unsec_o, 1'b1);
    chk("R10 enable set", dbg_enabled_o, 1'b1);
    tick();
    send(3'd5, 8'h00, 1'b0, 1'b1, 1'b0, "R10 cpu read unlocked");
    send(3'd1, 8'h00, 1'b0, 1'b1, 1'b0, "R10 mem write unlocked");

    // secured special, flash not erased
    do_reset(1'b1, 1'b1);
    pulse_erase(1'b0);
    chk("R11 unsec stays low", unsec_o, 1'b0);
    chk("R11 enable set", dbg_enabled_o, 1'b1);
    tick();
    send(3'd1, 8'h00, 1'b0, 1'b1, 1'b0, "R11 mem write allowed");
    send(3'd5, 8'h00, 1'b0, 1'b0, 1'b0, "R11 cpu read locked");
    send(3'd7, 8'h00, 1'b0, 1'b0, 1'b0, "R11 exit locked");
    chk("R11 fw permit low", fw_permit_o, 1'b0);

    repeat (3) tick();
    ntests++;
    if (exp_q.size() != 0) begin
      nfail++;
      $display("FAIL R3 missing responses actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule